// File: doc/BRIEF.md
# Per-Codec Response Tracker

This block keeps the books for a serial codec link on which one host issues command words to up to sixteen codec addresses and collects their answers from a response ring. Each issued command is charged to the codec named in its top nibble. Each answer arrives as a payload word plus an extended word whose low nibble names the codec that sent it. A solicited answer settles one outstanding command for its codec, and its payload becomes that codec's result. An unsolicited answer is passed straight on as an event and leaves every count alone.

Answers that cannot be matched are flagged as errors of two distinct kinds. An answer from an address the block does not track raises the bad-address pulse. A solicited answer from a codec that has nothing outstanding raises the spurious pulse. The spurious report carries the codec number, the orphan payload and the last command sent to that codec, so that the consumer can log what the codec may have been answering. Software polls a codec's busy bit through the read port and, once the bit is clear, reads the stored result from the same port. Timeouts stay in software.

Top module: `codec_resp_tracker`

## Requirements
- R1: The codec of an issued command is `cmd_word[31:28]`. A value at or above `NUM_CODECS` is charged to codec 0.
- R2: Each command strobe adds one to its codec's outstanding count, so `busy_vec[codec]` is 1 after the next rising edge. The command word is kept as that codec's last command.
- R3: The codec of a response is `rsp_ext[3:0]`. A response with a value at or above `NUM_CODECS` raises `err_addr` for exactly the cycle after the strobe. It changes no count, no stored result and no other output.
- R4: A response from a legal address with `rsp_ext[4]` = 1 is unsolicited. In the cycle after the strobe, `evt_valid` is 1 and `evt_data`/`evt_ext` carry the payload and extended word. No count changes.
- R5: A solicited response (`rsp_ext[4]` = 0) to a codec with a nonzero count stores `rsp_data` as that codec's result and takes one off its count.
- R6: A solicited response to a codec whose count is zero, with no command for that codec in the same cycle, raises `err_spur` for one cycle. `err_spur_codec`, `err_spur_data` and `err_spur_cmd` then carry the codec, the payload and the last command sent to that codec. The stored result is left unchanged.
- R7: `rd_busy` is 1 exactly when the count of codec `rd_addr` is nonzero. `rd_resp` is that codec's stored result. For `rd_addr` at or above `NUM_CODECS`, both read as 0.
- R8: A command and a solicited response for the same codec in the same cycle leave its count unchanged, store the payload and raise no error.
- R9: A count stops at 2^`CNT_W`-1. Further commands do not wrap it.
- R10: While `rst_n` is 0, all counts, stored results, last commands and output pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_word | input | 32 | Issued command word; bits 31:28 name the codec |
| rsp_valid | input | 1 | A response is taken from the ring this cycle |
| rsp_data | input | 32 | Response payload |
| rsp_ext | input | 32 | Extended word; bits 3:0 codec, bit 4 unsolicited |
| rd_addr | input | 4 | Codec selected on the read port |
| rd_busy | output | 1 | Selected codec still has commands outstanding |
| rd_resp | output | 32 | Latest stored result of the selected codec |
| busy_vec | output | NUM_CODECS | Per-codec outstanding flag |
| evt_valid | output | 1 | Unsolicited event pulse |
| evt_data | output | 32 | Event payload |
| evt_ext | output | 32 | Event extended word |
| err_addr | output | 1 | Response from an untracked address |
| err_spur | output | 1 | Solicited response with nothing outstanding |
| err_spur_codec | output | 4 | Codec of the spurious response |
| err_spur_data | output | 32 | Payload of the spurious response |
| err_spur_cmd | output | 32 | Last command sent to that codec |

## Verification
The bench builds the block with `NUM_CODECS` = 12 and `CNT_W` = 3. With 12 codecs, four of the sixteen nibble values are untracked. Random traffic therefore often hits both the remapping of command addresses to codec 0 and the bad-address error. A 3-bit count saturates after seven commands, so a directed burst of nine commands, followed by a drain of seven answers and one more, shows the count stopping rather than wrapping.

// File: rtl/codec_resp_tracker.sv
module codec_resp_tracker #(
  parameter int NUM_CODECS = 15,
  parameter int CNT_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [31:0]           cmd_word,
  input  logic                  rsp_valid,
  input  logic [31:0]           rsp_data,
  input  logic [31:0]           rsp_ext,
  input  logic [3:0]            rd_addr,
  output logic                  rd_busy,
  output logic [31:0]           rd_resp,
  output logic [NUM_CODECS-1:0] busy_vec,
  output logic                  evt_valid,
  output logic [31:0]           evt_data,
  output logic [31:0]           evt_ext,
  output logic                  err_addr,
  output logic                  err_spur,
  output logic [3:0]            err_spur_codec,
  output logic [31:0]           err_spur_data,
  output logic [31:0]           err_spur_cmd
);
  localparam logic [4:0]       NC      = 5'(NUM_CODECS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q  [NUM_CODECS];
  logic [31:0]      lcmd_q [NUM_CODECS];
  logic [31:0]      lres_q [NUM_CODECS];

  wire [3:0] cmd_field = cmd_word[31:28];
  wire [3:0] cmd_codec = ({1'b0, cmd_field} < NC) ? cmd_field : 4'd0;
  wire [3:0] rsp_addr  = rsp_ext[3:0];
  wire       rsp_legal = {1'b0, rsp_addr} < NC;
  wire       rsp_unsol = rsp_ext[4];
  wire       rsp_sol   = rsp_valid && rsp_legal && !rsp_unsol;
  wire       same_cmd  = cmd_valid && (cmd_codec == rsp_addr);
  wire       rsp_open  = rsp_legal && (cnt_q[rsp_addr] != '0);
  wire       matched   = rsp_sol && (rsp_open || same_cmd);
  wire       spurious  = rsp_sol && !matched;
  wire       rd_legal  = {1'b0, rd_addr} < NC;

  for (genvar c = 0; c < NUM_CODECS; c++) begin : g_codec
    wire hit_cmd = cmd_valid && (cmd_codec == 4'(c));
    wire hit_rsp = matched && (rsp_addr == 4'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[c]  <= '0;
        lcmd_q[c] <= '0;
        lres_q[c] <= '0;
      end else begin
        case ({hit_cmd, hit_rsp})
          2'b10:   if (cnt_q[c] != CNT_MAX) cnt_q[c] <= cnt_q[c] + 1'b1;
          2'b01:   cnt_q[c] <= cnt_q[c] - 1'b1;
          default: cnt_q[c] <= cnt_q[c];
        endcase
        if (hit_cmd) lcmd_q[c] <= cmd_word;
        if (hit_rsp) lres_q[c] <= rsp_data;
      end
    end

    assign busy_vec[c] = cnt_q[c] != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid      <= 1'b0;
      evt_data       <= '0;
      evt_ext        <= '0;
      err_addr       <= 1'b0;
      err_spur       <= 1'b0;
      err_spur_codec <= '0;
      err_spur_data  <= '0;
      err_spur_cmd   <= '0;
    end else begin
      evt_valid <= rsp_valid && rsp_legal && rsp_unsol;
      err_addr  <= rsp_valid && !rsp_legal;
      err_spur  <= spurious;
      if (rsp_valid && rsp_legal && rsp_unsol) begin
        evt_data <= rsp_data;
        evt_ext  <= rsp_ext;
      end
      if (spurious) begin
        err_spur_codec <= rsp_addr;
        err_spur_data  <= rsp_data;
        err_spur_cmd   <= lcmd_q[rsp_addr];
      end
    end
  end

  assign rd_busy = rd_legal && busy_vec[rd_addr];
  assign rd_resp = rd_legal ? lres_q[rd_addr] : 32'd0;
endmodule

module codec_resp_tracker_chk #(
  parameter int NUM_CODECS = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [31:0]           cmd_word,
  input logic                  rsp_valid,
  input logic [31:0]           rsp_data,
  input logic [31:0]           rsp_ext,
  input logic [3:0]            rd_addr,
  input logic                  rd_busy,
  input logic [NUM_CODECS-1:0] busy_vec,
  input logic                  evt_valid,
  input logic [31:0]           evt_data,
  input logic                  err_addr,
  input logic                  err_spur
);
  localparam logic [4:0] NC = 5'(NUM_CODECS);
  wire       legal = {1'b0, rsp_ext[3:0]} < NC;
  wire [3:0] cidx  = ({1'b0, cmd_word[31:28]} < NC) ? cmd_word[31:28] : 4'd0;

  a_r2_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_valid) |=> busy_vec[$past(cidx)]);
  a_r3_bad_addr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !legal) |=> (err_addr && !evt_valid && !err_spur));
  a_r3_bad_addr_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !legal && !cmd_valid) |=> $stable(busy_vec));
  a_r4_event_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && legal && rsp_ext[4]) |=> (evt_valid && evt_data == $past(rsp_data)));
  a_r4_event_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && legal && rsp_ext[4] && !cmd_valid) |=> $stable(busy_vec));
  a_r6_no_error_without_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> (!err_spur && !err_addr && !evt_valid));
  a_r5_idle_holds_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !rsp_valid) |=> $stable(busy_vec));
  a_r7_busy_only_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> ({1'b0, rd_addr} < NC));
  a_r6_errors_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_valid, err_addr, err_spur}));
endmodule

bind codec_resp_tracker codec_resp_tracker_chk #(.NUM_CODECS(NUM_CODECS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ext(rsp_ext),
  .rd_addr(rd_addr), .rd_busy(rd_busy), .busy_vec(busy_vec),
  .evt_valid(evt_valid), .evt_data(evt_data), .err_addr(err_addr),
  .err_spur(err_spur)
);

// File: tb/codec_resp_tracker_tb_top.sv
`timescale 1ns/1ps
module codec_resp_tracker_tb_top;
  localparam int N    = 12;
  localparam int CW   = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_valid = 1'b0;
  logic [31:0] cmd_word = '0, rsp_data = '0, rsp_ext = '0;
  logic [3:0] rd_addr = '0;
  logic rd_busy, evt_valid, err_addr, err_spur;
  logic [31:0] rd_resp, evt_data, evt_ext, err_spur_data, err_spur_cmd;
  logic [3:0] err_spur_codec;
  logic [N-1:0] busy_vec;

  always #2 clk = ~clk;

  codec_resp_tracker #(.NUM_CODECS(N), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ext(rsp_ext),
    .rd_addr(rd_addr), .rd_busy(rd_busy), .rd_resp(rd_resp), .busy_vec(busy_vec),
    .evt_valid(evt_valid), .evt_data(evt_data), .evt_ext(evt_ext),
    .err_addr(err_addr), .err_spur(err_spur), .err_spur_codec(err_spur_codec),
    .err_spur_data(err_spur_data), .err_spur_cmd(err_spur_cmd)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int cnt_m [16];
  logic [31:0] lcmd_m [16];
  logic [31:0] lres_m [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin
      cnt_m[i] = 0; lcmd_m[i] = '0; lres_m[i] = '0;
    end
  endtask

  function automatic logic [N-1:0] exp_busy();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = cnt_m[i] != 0;
    return v;
  endfunction

  task automatic check_read(input logic [3:0] ra);
    logic [31:0] er;
    bit eb;
    eb = (ra < N) && (cnt_m[ra] != 0);
    er = (ra < N) ? lres_m[ra] : 32'd0;
    chk(rd_busy == eb, "R7 rd_busy", {31'd0, rd_busy}, {31'd0, eb});
    chk(rd_resp == er, "R7 rd_resp", rd_resp, er);
  endtask

  task automatic step(input bit cv, input logic [31:0] cw, input bit rv,
                      input logic [31:0] rd, input logic [31:0] re, input logic [3:0] ra);
    int ci, ri;
    bit e_evt, e_bad, e_spur, match;
    logic [31:0] e_scmd;
    @(negedge clk);
    cmd_valid = cv; cmd_word = cw; rsp_valid = rv; rsp_data = rd; rsp_ext = re; rd_addr = ra;
    ci = (cw[31:28] < N) ? int'(cw[31:28]) : 0;
    ri = int'(re[3:0]);
    e_evt = 0; e_bad = 0; e_spur = 0; match = 0; e_scmd = '0;
    if (rv) begin
      if (ri >= N) e_bad = 1;
      else if (re[4]) e_evt = 1;
      else if (cnt_m[ri] != 0 || (cv && ci == ri)) match = 1;
      else begin e_spur = 1; e_scmd = lcmd_m[ri]; end
    end
    if (cv && match && ci == ri) lres_m[ri] = rd;
    else begin
      if (cv && cnt_m[ci] < MAXC) cnt_m[ci]++;
      if (match) begin cnt_m[ri]--; lres_m[ri] = rd; end
    end
    if (cv) lcmd_m[ci] = cw;
    @(posedge clk); #1;
    chk(evt_valid == e_evt, "R4 evt_valid", {31'd0, evt_valid}, {31'd0, e_evt});
    if (e_evt) begin
      chk(evt_data == rd, "R4 evt_data", evt_data, rd);
      chk(evt_ext == re, "R4 evt_ext", evt_ext, re);
    end
    chk(err_addr == e_bad, "R3 err_addr", {31'd0, err_addr}, {31'd0, e_bad});
    chk(err_spur == e_spur, "R6 err_spur", {31'd0, err_spur}, {31'd0, e_spur});
    if (e_spur) begin
      chk(err_spur_codec == re[3:0], "R6 codec", {28'd0, err_spur_codec}, {28'd0, re[3:0]});
      chk(err_spur_data == rd, "R6 data", err_spur_data, rd);
      chk(err_spur_cmd == e_scmd, "R6 last cmd", err_spur_cmd, e_scmd);
    end
    chk(busy_vec == exp_busy(), "R2/R5/R8 busy_vec", 32'(busy_vec), 32'(exp_busy()));
    check_read(ra);
    cmd_valid = 0; rsp_valid = 0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic [3:0] a, input logic [27:0] body);
    return {a, body};
  endfunction

  function automatic logic [31:0] mk_ext(input logic [3:0] a, input bit unsol);
    return {27'h15a0c3, unsol, a};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    model_clear();
    #1;
    chk(busy_vec == '0, "R10 busy in reset", 32'(busy_vec), 0);
    chk(!evt_valid && !err_addr && !err_spur, "R10 pulses in reset",
        {29'd0, evt_valid, err_addr, err_spur}, 0);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #0.1;
      chk(rd_resp == 0 && !rd_busy, "R10 read port in reset", rd_resp, 0);
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    do_reset();

    // R1: address 14 is untracked with 12 codecs, so it charges codec 0
    step(1, mk_cmd(4'd14, 28'h0000abc), 0, 0, 0, 4'd0);
    chk(busy_vec[0] == 1'b1, "R1 remap to codec 0", {31'd0, busy_vec[0]}, 1);
    step(0, 0, 1, 32'h11110000, mk_ext(4'd0, 0), 4'd0);
    chk(rd_resp == 32'h11110000, "R5 result stored", rd_resp, 32'h11110000);

    // R8: same-cycle issue and answer on an idle codec
    step(1, mk_cmd(4'd3, 28'h1234567), 1, 32'hcafe0003, mk_ext(4'd3, 0), 4'd3);
    chk(!rd_busy && rd_resp == 32'hcafe0003, "R8 same cycle", rd_resp, 32'hcafe0003);

    // R6: spurious answer reports last command of codec 3
    step(0, 0, 1, 32'hdead0003, mk_ext(4'd3, 0), 4'd3);
    chk(err_spur_cmd == mk_cmd(4'd3, 28'h1234567), "R6 spur cmd", err_spur_cmd, mk_cmd(4'd3, 28'h1234567));
    chk(rd_resp == 32'hcafe0003, "R6 result kept", rd_resp, 32'hcafe0003);

    // R3: untracked response address
    step(0, 0, 1, 32'h0badadd0, mk_ext(4'd13, 0), 4'd13);
    chk(err_addr == 1'b1, "R3 bad address", {31'd0, err_addr}, 1);

    // R4: unsolicited event on a busy codec leaves it busy
    step(1, mk_cmd(4'd7, 28'h7), 0, 0, 0, 4'd7);
    step(0, 0, 1, 32'h0e0e0e0e, mk_ext(4'd7, 1), 4'd7);
    chk(rd_busy == 1'b1, "R4 no count change", {31'd0, rd_busy}, 1);
    step(0, 0, 1, 32'h77777777, mk_ext(4'd7, 0), 4'd7);

    // R9: nine issues to codec 5, count stops at 7
    for (int i = 0; i < 9; i++) step(1, mk_cmd(4'd5, 28'(i)), 0, 0, 0, 4'd5);
    for (int i = 0; i < 7; i++) step(0, 0, 1, 32'(i), mk_ext(4'd5, 0), 4'd5);
    chk(rd_busy == 1'b0, "R9 saturated drain", {31'd0, rd_busy}, 0);
    step(0, 0, 1, 32'h55, mk_ext(4'd5, 0), 4'd5);
    chk(err_spur == 1'b1, "R9 extra answer spurious", {31'd0, err_spur}, 1);

    // R7: untracked read address reads zero
    step(0, 0, 0, 0, 0, 4'd15);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] cw, re;
      cw = $urandom; re = $urandom;
      re[4] = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 3) != 0) re[3:0] = cw[31:28];
      step($urandom_range(0, 9) < 5, cw, $urandom_range(0, 9) < 5, $urandom, re,
           4'($urandom_range(0, 15)));
      if (i == 1500) do_reset();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule